// File: doc/BRIEF.md
# Clock Source Lock and Slip Monitor

The monitor observes eleven external sample-clock sources. Each source gives a lock level, which may be asynchronous to the block clock, and a slip pulse, which is synchronous to it. The monitor folds these into one 32-bit extended status word for a quadlet-addressed register file. The low field holds the synchronized live lock state of every source. A higher field holds sticky slip flags, which a quadlet read of the status word clears.

Any change in the live lock field raises a one-cycle event pulse for the notification logic. Slips never raise it. A second output reports the lock state of the source picked by a clock-source select index, and that output has its own one-cycle change pulse. Lock inputs cross into the block clock domain through a parameterized synchronizer chain before any edge detection.

Top module: `clkmon_top`

## Requirements
- R1: Lock field bits 0..10 carry the sources in the order AES1, AES2, AES3, AES4, ADAT, TDIF, ARX1, ARX2, ARX3, ARX4, word clock. A level change on `lock_i[n]` shows in status bit n after two clock edges.
- R2: `lock_evt_o` is high for exactly one cycle, in the same cycle that the synchronized lock field changes, whether a bit rises or falls. It stays low while the field is stable.
- R3: A pulse on `slip_i[n]` sets status bit 16+n from the next cycle on. The bit stays set, with no further pulse, until it is cleared by a read.
- R4: While `rd_i` is high the status word still shows the sticky slip bits. After that edge, every slip bit without a fresh pulse reads 0.
- R5: A slip pulse in the same cycle as `rd_i` leaves its bit set after the read.
- R6: Slip pulses never raise `lock_evt_o` or `sel_lock_evt_o`.
- R7: Status bits 11..15 and 27..31 always read 0.
- R8: `sel_locked_o` follows `src_sel_i` with this encoding:
  - 0..3 select AES1..AES4.
  - 4 selects the OR of the four AES lock bits.
  - 5 selects ADAT, 6 selects TDIF and 7 selects word clock.
  - 8..11 select ARX1..ARX4.
  - 12 (internal) is always locked.
  - 13..15 are never locked.
- R9: `sel_lock_evt_o` pulses for one cycle when the selected lock state changes because of a lock change. Changes on other sources do not raise it, and neither does a change of `src_sel_i`.
- R10: During and right after reset, the status word is 0 and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| lock_i | input | 11 | Per-source lock levels (asynchronous) |
| slip_i | input | 11 | Per-source slip pulses (synchronous) |
| src_sel_i | input | 4 | Selected clock source index |
| rd_i | input | 1 | Quadlet read strobe of the status word |
| status_o | output | 32 | Extended status word |
| lock_evt_o | output | 1 | Any lock change pulse |
| sel_locked_o | output | 1 | Lock state of the selected source |
| sel_lock_evt_o | output | 1 | Selected source lock change pulse |

## Verification
The embedded properties check three things on every cycle. First, the sticky flags hold, set and clear with set winning over clear. Second, every change of the synchronized lock field is accompanied by the event pulse, and a selected-source pulse never comes without a global one. Third, the internal source always reports locked. Only the bench's sweeps can show the following: the exact bit placement and source order, the two-cycle synchronizer latency, the full select-index mapping across all lock patterns, and the absence of pulses when the select index or slips change.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
   localparam int unsigned SRC_CNT = 11;
   localparam int unsigned SEL_W   = 4;

   // lock vector bit positions (status layout depends on them)
   localparam int unsigned LB_AES1 = 0;
   localparam int unsigned LB_AES4 = 3;
   localparam int unsigned LB_ADAT = 4;
   localparam int unsigned LB_TDIF = 5;
   localparam int unsigned LB_ARX1 = 6;
   localparam int unsigned LB_WCLK = 10;

   // select index encoding
   localparam logic [SEL_W-1:0] SEL_AES_ANY  = 4'd4;
   localparam logic [SEL_W-1:0] SEL_ADAT     = 4'd5;
   localparam logic [SEL_W-1:0] SEL_TDIF     = 4'd6;
   localparam logic [SEL_W-1:0] SEL_WCLK     = 4'd7;
   localparam logic [SEL_W-1:0] SEL_ARX_LO   = 4'd8;
   localparam logic [SEL_W-1:0] SEL_ARX_HI   = 4'd11;
   localparam logic [SEL_W-1:0] SEL_INTERNAL = 4'd12;

   typedef logic [SRC_CNT-1:0] src_vec_t;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
   parameter int unsigned WIDTH  = 11,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      assert (STAGES >= 2) else $error("clkmon_sync: STAGES must be at least 2");
   end

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_i[b]};
         end
         assign q_o[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/clkmon_slip.sv
module clkmon_slip #(
   parameter int unsigned WIDTH = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] slip_i,
   input  logic             rd_i,
   output logic [WIDTH-1:0] flags_o
);
   logic [WIDTH-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (rd_i ? '0 : flags_q) | slip_i;
   end

   assign flags_o = flags_q;

   // R3
   slip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
   // R5
   slip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|slip_i) |=> ((flags_q & $past(slip_i)) == $past(slip_i)));
   // R4
   slip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !(|slip_i)) |=> (flags_q == '0));
endmodule

// File: rtl/clkmon_selmux.sv
module clkmon_selmux
   import clkmon_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  src_vec_t         cur_i,
   input  src_vec_t         prev_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             locked_o,
   output logic             chg_o
);
   function automatic logic pick(input src_vec_t v, input logic [SEL_W-1:0] s);
      logic r;
      if (s <= 4'd3)                          r = v[LB_AES1 + int'(s)];
      else if (s == SEL_AES_ANY)              r = |v[LB_AES4:LB_AES1];
      else if (s == SEL_ADAT)                 r = v[LB_ADAT];
      else if (s == SEL_TDIF)                 r = v[LB_TDIF];
      else if (s == SEL_WCLK)                 r = v[LB_WCLK];
      else if (s >= SEL_ARX_LO && s <= SEL_ARX_HI)
                                              r = v[LB_ARX1 + int'(s - SEL_ARX_LO)];
      else if (s == SEL_INTERNAL)             r = 1'b1;
      else                                    r = 1'b0;
      return r;
   endfunction

   logic now_l, was_l;
   always_comb begin
      now_l    = pick(cur_i, sel_i);
      was_l    = pick(prev_i, sel_i);
      locked_o = now_l;
      chg_o    = now_l ^ was_l;
   end

   // R8
   sel_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SEL_INTERNAL) |-> (locked_o && !chg_o));
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
   import clkmon_pkg::*;
#(
   parameter int unsigned STATUS_W    = 32,
   parameter int unsigned SLIP_LSB    = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SRC_CNT-1:0]  lock_i,
   input  logic [SRC_CNT-1:0]  slip_i,
   input  logic [SEL_W-1:0]    src_sel_i,
   input  logic                rd_i,
   output logic [STATUS_W-1:0] status_o,
   output logic                lock_evt_o,
   output logic                sel_locked_o,
   output logic                sel_lock_evt_o
);
   localparam int unsigned SLIP_MSB = SLIP_LSB + SRC_CNT - 1;

   initial begin
      assert (SLIP_LSB >= SRC_CNT) else $error("clkmon_top: slip field overlaps lock field");
      assert (SLIP_MSB < STATUS_W) else $error("clkmon_top: slip field exceeds status word");
   end

   src_vec_t lock_s, lock_q, slip_q;

   clkmon_sync #(.WIDTH(SRC_CNT), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_i(lock_i), .q_o(lock_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= '0;
      else        lock_q <= lock_s;
   end

   assign lock_evt_o = |(lock_s ^ lock_q);

   clkmon_slip #(.WIDTH(SRC_CNT)) i_slip (
      .clk(clk), .rst_n(rst_n), .slip_i(slip_i), .rd_i(rd_i), .flags_o(slip_q));

   clkmon_selmux i_selmux (
      .clk(clk), .rst_n(rst_n), .cur_i(lock_s), .prev_i(lock_q), .sel_i(src_sel_i),
      .locked_o(sel_locked_o), .chg_o(sel_lock_evt_o));

   always_comb begin
      status_o                       = '0;
      status_o[SRC_CNT-1:0]          = lock_s;
      status_o[SLIP_MSB:SLIP_LSB]    = slip_q;
   end

   // R2
   lock_evt_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lock_s) |-> lock_evt_o);
   // R9
   sel_evt_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_lock_evt_o |-> lock_evt_o);
   // R6
   slip_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(lock_s) |-> !lock_evt_o);
endmodule

// File: tb/test_clkmon_top.sv
`timescale 1ns/1ps
module test_clkmon_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] lock_i = '0;
   logic [10:0] slip_i = '0;
   logic [3:0]  src_sel_i = '0;
   logic        rd_i = 1'b0;
   logic [31:0] status_o;
   logic        lock_evt_o, sel_locked_o, sel_lock_evt_o;

   int n_vec = 0;
   int n_bad = 0;
   logic [10:0] exp_lock = '0;
   logic [10:0] exp_slip = '0;

   always #5 clk = ~clk;

   clkmon_top i_clkmon_top (
      .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .slip_i(slip_i),
      .src_sel_i(src_sel_i), .rd_i(rd_i), .status_o(status_o),
      .lock_evt_o(lock_evt_o), .sel_locked_o(sel_locked_o),
      .sel_lock_evt_o(sel_lock_evt_o));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic sel_exp(input logic [10:0] v, input int s);
      if (s < 4)        return v[s];
      else if (s == 4)  return |v[3:0];
      else if (s == 5)  return v[4];
      else if (s == 6)  return v[5];
      else if (s == 7)  return v[10];
      else if (s < 12)  return v[s - 2];
      else if (s == 12) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [31:0] word_exp();
      return {5'b0, exp_slip, 5'b0, exp_lock};
   endfunction

   // change lock inputs to v at a negedge, check event timing and sel pulse
   task automatic set_lock(input logic [10:0] v);
      logic old_sel;
      logic changed;
      old_sel  = sel_exp(exp_lock, int'(src_sel_i));
      changed  = (v != exp_lock);
      lock_i   = v;
      @(negedge clk);
      chk("R1 sync latency", {31'b0, lock_evt_o}, 32'd0);
      @(negedge clk);
      exp_lock = v;
      chk("R1 lock field", status_o, word_exp());
      chk("R2 evt pulse", {31'b0, lock_evt_o}, {31'b0, changed});
      chk("R9 sel pulse", {31'b0, sel_lock_evt_o},
          {31'b0, old_sel ^ sel_exp(v, int'(src_sel_i))});
      @(negedge clk);
      chk("R2 evt width", {31'b0, lock_evt_o}, 32'd0);
      chk("R9 sel width", {31'b0, sel_lock_evt_o}, 32'd0);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 status in reset", status_o, 32'd0);
      chk("R10 evt in reset", {30'b0, lock_evt_o, sel_lock_evt_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 status after reset", status_o, 32'd0);
      chk("R10 evt after reset", {30'b0, lock_evt_o, sel_lock_evt_o}, 32'd0);

      // R1 R2 R9: toggle each source up then down, under every select index
      for (int s = 0; s < 16; s++) begin
         src_sel_i = 4'(s);
         for (int b = 0; b < 11; b++) begin
            set_lock(exp_lock | (11'd1 << b));
            set_lock(exp_lock & ~(11'd1 << b));
         end
      end

      // R8: select sweep over several lock patterns, no pulse on select change
      for (int p = 0; p < 24; p++) begin
         set_lock(11'((p * 11'h2B5 + p * p * 7) & 11'h7FF));
         for (int s = 0; s < 16; s++) begin
            src_sel_i = 4'(s);
            #1;
            chk("R8 sel locked", {31'b0, sel_locked_o}, {31'b0, sel_exp(exp_lock, s)});
            chk("R9 no pulse on select", {31'b0, sel_lock_evt_o}, 32'd0);
            chk("R7 unused zero", status_o & 32'hF800_F800, 32'd0);
         end
         @(negedge clk);
      end
      set_lock(11'h555);

      // R3 R4 R6: each slip bit set, held, read cleared
      for (int b = 0; b < 11; b++) begin
         slip_i = 11'd1 << b;
         @(negedge clk);
         slip_i = '0;
         exp_slip = 11'd1 << b;
         chk("R3 slip set", status_o, word_exp());
         chk("R6 no lock evt", {30'b0, lock_evt_o, sel_lock_evt_o}, 32'd0);
         repeat (3) @(negedge clk);
         chk("R3 slip held", status_o, word_exp());
         rd_i = 1'b1;
         #1;
         chk("R4 value during read", status_o, word_exp());
         @(negedge clk);
         rd_i = 1'b0;
         exp_slip = '0;
         chk("R4 cleared after read", status_o, word_exp());
      end

      // R3: accumulate several slips
      for (int b = 0; b < 11; b += 3) begin
         slip_i = 11'd1 << b;
         @(negedge clk);
         exp_slip |= 11'd1 << b;
      end
      slip_i = '0;
      chk("R3 slips accumulate", status_o, word_exp());

      // R5: slip coinciding with read, on a set and a clear bit
      for (int k = 0; k < 11; k++) begin
         slip_i = 11'd1 << k;
         rd_i = 1'b1;
         @(negedge clk);
         slip_i = '0;
         rd_i = 1'b0;
         exp_slip = 11'd1 << k;
         chk("R5 slip kept over read", status_o, word_exp());
      end
      rd_i = 1'b1;
      @(negedge clk);
      rd_i = 1'b0;
      exp_slip = '0;
      chk("R4 final clear", status_o, word_exp());

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule